// File: doc/BRIEF.md
# Crosspoint Matrix Configuration Controller

This block keeps the routing state for a matrix of 32 outputs by 32 inputs. Every output owns a 6-bit control word, so the block holds 192 configuration bits. There are two ways to load them. A serial stream goes into a 192-bit shift chain, and a serial output lets several devices share one chain. Parallel writes replace the single word of the output that a 5-bit address selects.

The storage has two ranks. Loads go only into the first rank. An update strobe copies the whole first rank into a second rank at once. Only the second rank feeds the decoders, so the routes that drive the matrix change together. Each output decoder turns its word into 32 one-hot crosspoint selects and one output enable. The matrix therefore gets 1024 select lines and 32 enables. An asynchronous reset clears both ranks, which disables every output.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: While rst_ni is low, both ranks clear at once, without waiting for a clock edge. This drives oen_o and sel_o to all zeros and ser_q_o to 0.
- R2: When par_mode_i=0, each rising clock with wr_ni=0 shifts the chain by one bit toward the output-31 end, and ser_d_i enters at bit 0. The stream order is the output-31 word first and the output-0 word last, with the most significant bit of each word first. After 192 shifts, word k holds the bits at chain positions [6k+5:6k].
- R3: ser_q_o always shows chain bit 191, the most significant bit of the output-31 word. A bit shifted in therefore appears on ser_q_o after 192 shifts, which allows daisy-chaining.
- R4: When par_mode_i=1, a rising clock with wr_ni=0 writes data_i into the word of output addr_i. All other words are left unchanged.
- R5: A clock edge with wr_ni=1 leaves the first rank unchanged in both modes, and ser_q_o keeps its value.
- R6: A rising clock with upd_ni=0 copies all 192 first-rank bits into the second rank. The new routes show on sel_o and oen_o after that edge. When a write and an update fall on the same edge, the copy takes the first-rank contents from before the write. Loads without an update do not change sel_o or oen_o.
- R7: Word encoding: bit 5 is the output enable (1 = enabled) and bits [4:0] give the input index. oen_o[k] equals bit 5 of the second-rank word k. sel_o[32*k+i] is 1 exactly when output k is enabled and its index is i.
- R8: Each output has at most one select line active at any time. A disabled output has none active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_mode_i | input | 1 | 1 = parallel addressed load, 0 = serial shift |
| wr_ni | input | 1 | Active-low write or shift enable |
| ser_d_i | input | 1 | Serial data in |
| ser_q_o | output | 1 | Serial data out (chain bit 191) |
| addr_i | input | 5 | Output number for parallel writes |
| data_i | input | 6 | Control word for parallel writes |
| upd_ni | input | 1 | Active-low update strobe |
| sel_o | output | 1024 | One-hot crosspoint selects, output k at [32k+31:32k] |
| oen_o | output | 32 | Per-output enable, 0 = high impedance |

## Verification
The bench loads a full 192-bit pattern serially. It then checks that each word landed in the right output and that bits come back out on ser_q_o exactly 192 shifts later; a reversed chain or a swapped bit order would route the wrong inputs. Parallel writes target addresses 0 and 31, and other words are checked for disturbance, which an off-by-one address decode would corrupt. Writes with the enable high and loads without an update must leave the routes alone. A design without true double buffering would move the routes early. Edges that combine a write and an update, and a reset in the middle of the run, catch a copy of the wrong rank and a reset that waits for the clock.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  parameter int unsigned N_OUT = 32;
  parameter int unsigned N_IN  = 32;
  parameter int unsigned IDX_W = $clog2(N_IN);
  parameter int unsigned FLD_W = IDX_W + 1;
  parameter int unsigned ADR_W = $clog2(N_OUT);
  parameter int unsigned CFG_W = N_OUT * FLD_W;
  parameter int unsigned SEL_W = N_OUT * N_IN;
endpackage

// File: rtl/xpt_first_rank.sv
module xpt_first_rank #(
  parameter int unsigned N_OUT = 32,
  parameter int unsigned FLD_W = 6,
  parameter int unsigned ADR_W = 5,
  localparam int unsigned CFG_W = N_OUT * FLD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             par_mode_i,
  input  logic             wr_ni,
  input  logic             ser_d_i,
  input  logic [ADR_W-1:0] addr_i,
  input  logic [FLD_W-1:0] data_i,
  output logic [CFG_W-1:0] rank_o,
  output logic             ser_q_o
);
  logic [CFG_W-1:0] rank_q;
  logic [CFG_W-1:0] shifted;
  logic             do_shift;

  assign do_shift = !wr_ni && !par_mode_i;
  assign shifted  = {rank_q[CFG_W-2:0], ser_d_i};

  for (genvar k = 0; k < N_OUT; k++) begin : g_fld
    logic hit;
    assign hit = !wr_ni && par_mode_i && (addr_i == ADR_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       rank_q[k*FLD_W +: FLD_W] <= '0;
      else if (do_shift) rank_q[k*FLD_W +: FLD_W] <= shifted[k*FLD_W +: FLD_W];
      else if (hit)      rank_q[k*FLD_W +: FLD_W] <= data_i;
    end
  end

  assign rank_o  = rank_q;
  assign ser_q_o = rank_q[CFG_W-1];
endmodule

// File: rtl/xpt_update_latch.sv
module xpt_update_latch #(
  parameter int unsigned CFG_W = 192
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_ni,
  input  logic [CFG_W-1:0] rank_i,
  output logic [CFG_W-1:0] live_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      live_o <= '0;
    else if (!upd_ni) live_o <= rank_i;
  end
endmodule

// File: rtl/xpt_out_decoder.sv
module xpt_out_decoder #(
  parameter int unsigned N_IN  = 32,
  parameter int unsigned IDX_W = 5,
  localparam int unsigned FLD_W = IDX_W + 1
) (
  input  logic [FLD_W-1:0] fld_i,
  output logic [N_IN-1:0]  sel_o,
  output logic             oen_o
);
  logic             en;
  logic [IDX_W-1:0] idx;

  assign en    = fld_i[FLD_W-1];
  assign idx   = fld_i[IDX_W-1:0];
  assign oen_o = en;

  for (genvar i = 0; i < N_IN; i++) begin : g_sel
    assign sel_o[i] = en && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
  import xpt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             par_mode_i,
  input  logic             wr_ni,
  input  logic             ser_d_i,
  output logic             ser_q_o,
  input  logic [ADR_W-1:0] addr_i,
  input  logic [FLD_W-1:0] data_i,
  input  logic             upd_ni,
  output logic [SEL_W-1:0] sel_o,
  output logic [N_OUT-1:0] oen_o
);
  logic [CFG_W-1:0] rank1;
  logic [CFG_W-1:0] rank2;

  xpt_first_rank #(
    .N_OUT(N_OUT), .FLD_W(FLD_W), .ADR_W(ADR_W)
  ) u_rank1 (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .par_mode_i(par_mode_i),
    .wr_ni     (wr_ni),
    .ser_d_i   (ser_d_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .rank_o    (rank1),
    .ser_q_o   (ser_q_o)
  );

  xpt_update_latch #(.CFG_W(CFG_W)) u_rank2 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_ni(upd_ni),
    .rank_i(rank1),
    .live_o(rank2)
  );

  for (genvar k = 0; k < N_OUT; k++) begin : g_dec
    xpt_out_decoder #(.N_IN(N_IN), .IDX_W(IDX_W)) u_dec (
      .fld_i(rank2[k*FLD_W +: FLD_W]),
      .sel_o(sel_o[k*N_IN +: N_IN]),
      .oen_o(oen_o[k])
    );
  end
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk
  import xpt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_ni,
  input logic             upd_ni,
  input logic             ser_q_o,
  input logic [SEL_W-1:0] sel_o,
  input logic [N_OUT-1:0] oen_o,
  input logic [CFG_W-1:0] rank1_i
);
  assert_idle_chain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ni |=> $stable(ser_q_o));

  assert_hold_routes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_ni |=> ($stable(sel_o) && $stable(oen_o)));

  assert_reset_off_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (oen_o == '0 && sel_o == '0 && !ser_q_o));

  for (genvar k = 0; k < N_OUT; k++) begin : g_chk
    assert_one_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sel_o[k*N_IN +: N_IN]));

    assert_off_no_sel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oen_o[k] |-> (sel_o[k*N_IN +: N_IN] == '0));

    assert_copy_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !upd_ni |=> (oen_o[k] == $past(rank1_i[k*FLD_W + FLD_W - 1])));
  end
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_ni  (wr_ni),
  .upd_ni (upd_ni),
  .ser_q_o(ser_q_o),
  .sel_o  (sel_o),
  .oen_o  (oen_o),
  .rank1_i(rank1)
);

// File: tb/xpt_cfg_ctrl_tb_top.sv
module xpt_cfg_ctrl_tb_top;
  import xpt_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_MAX   = 100000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             par_mode_i = 1'b0;
  logic             wr_ni = 1'b1;
  logic             ser_d_i = 1'b0;
  logic             ser_q_o;
  logic [ADR_W-1:0] addr_i = '0;
  logic [FLD_W-1:0] data_i = '0;
  logic             upd_ni = 1'b1;
  logic [SEL_W-1:0] sel_o;
  logic [N_OUT-1:0] oen_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [CFG_W-1:0] m1 = '0;
  logic [CFG_W-1:0] m2 = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xpt_cfg_ctrl dut_i (.*);

  function automatic logic [SEL_W-1:0] exp_sel(input logic [CFG_W-1:0] r);
    logic [SEL_W-1:0] s = '0;
    for (int k = 0; k < N_OUT; k++)
      if (r[k*FLD_W + FLD_W - 1]) s[k*N_IN + int'(r[k*FLD_W +: IDX_W])] = 1'b1;
    return s;
  endfunction

  function automatic logic [N_OUT-1:0] exp_oen(input logic [CFG_W-1:0] r);
    logic [N_OUT-1:0] e;
    for (int k = 0; k < N_OUT; k++) e[k] = r[k*FLD_W + FLD_W - 1];
    return e;
  endfunction

  task automatic check_all(input string tag);
    checks++;
    if (oen_o !== exp_oen(m2)) begin
      fails++; $display("FAIL %s oen_o act=%h exp=%h", tag, oen_o, exp_oen(m2));
    end
    checks++;
    if (sel_o !== exp_sel(m2)) begin
      fails++; $display("FAIL %s sel_o act=%h exp=%h", tag, sel_o, exp_sel(m2));
    end
    checks++;
    if (ser_q_o !== m1[CFG_W-1]) begin
      fails++; $display("FAIL %s ser_q_o act=%b exp=%b", tag, ser_q_o, m1[CFG_W-1]);
    end
  endtask

  // one clock: drive at negedge, model at posedge, inputs released afterwards
  task automatic cyc(input logic pm, input logic wn, input logic sd,
                     input logic [ADR_W-1:0] a, input logic [FLD_W-1:0] d,
                     input logic un);
    logic [CFG_W-1:0] old1;
    par_mode_i = pm; wr_ni = wn; ser_d_i = sd; addr_i = a; data_i = d; upd_ni = un;
    @(posedge clk_i);
    old1 = m1;
    if (!wn) begin
      if (!pm) m1 = {m1[CFG_W-2:0], sd};
      else     m1[int'(a)*FLD_W +: FLD_W] = d;
    end
    if (!un) m2 = old1;
    @(negedge clk_i);
    wr_ni = 1'b1; upd_ni = 1'b1;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WDOG_MAX) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<=%0d", cycles, WDOG_MAX);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CFG_W-1:0] pat;
    void'($urandom(32'd20240611));
    @(negedge clk_i);
    check_all("R1 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 serial load: output 31 first, MSB first; enable all and route out k to input 31-k
    pat = '0;
    for (int k = 0; k < N_OUT; k++) pat[k*FLD_W +: FLD_W] = {1'b1, IDX_W'(N_OUT-1-k)};
    for (int b = CFG_W-1; b >= 0; b--) cyc(1'b0, 1'b0, pat[b], '0, '0, 1'b1);
    check_all("R6 no update yet");
    cyc(1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
    check_all("R2 serial load");
    checks++;
    if (sel_o[3*N_IN + 28] !== 1'b1) begin
      fails++; $display("FAIL R7 out3 sel act=%b exp=1", sel_o[3*N_IN + 28]);
    end

    // R3 daisy chain: first bits reappear on ser_q_o
    for (int b = CFG_W-1; b >= CFG_W-12; b--) begin
      checks++;
      if (ser_q_o !== pat[b]) begin
        fails++; $display("FAIL R3 bit%0d act=%b exp=%b", b, ser_q_o, pat[b]);
      end
      cyc(1'b0, 1'b0, 1'b0, '0, '0, 1'b1);
    end
    check_all("R3 chain");

    // R5 wr_ni high in both modes
    cyc(1'b1, 1'b1, 1'b1, 5'd0, 6'h3f, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 5'd0, 6'h3f, 1'b0);
    check_all("R5 no write");

    // R4 parallel writes at address edges
    cyc(1'b1, 1'b0, 1'b0, 5'd0, 6'h25, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 5'd31, 6'h00, 1'b0);
    check_all("R4 addr0/31");

    // R6 write and update on same edge copies pre-write contents
    cyc(1'b1, 1'b0, 1'b0, 5'd7, 6'h2a, 1'b0);
    check_all("R6 same edge");
    cyc(1'b1, 1'b1, 1'b0, 5'd7, 6'h00, 1'b0);
    check_all("R6 follow-up");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r = $urandom;
      cyc(r[0], r[1] & r[2], r[3], r[8:4], r[14:9], !(r[15] && r[16]));
      check_all("R4/R2/R6/R7/R8 random");
    end

    // R1 asynchronous reset mid-run
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    m1 = '0; m2 = '0;
    #1;
    check_all("R1 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule